// File: doc/BRIEF.md
# Waveform Timer Channel

A single counter channel that produces two digital outputs, A and B, from events. The counter advances on a clock-enable strobe and follows one of four count styles. It can count up and wrap at full scale. It can count up and back down. It can count up and restart after reaching a compare value C. It can count up and down, turning around at C. Each step of the counter is checked against three compare registers: RA, RB and RC. A detected edge on an external event input is also an event, and so is a software trigger written through the register port. For every event, each output has its own 2-bit action field that can do nothing, set the output, clear it or toggle it.

Software drives the channel through a word-addressed register port. The port reaches the command, mode and compare registers, the counter value, a sticky status word and an interrupt mask. The single interrupt line is the OR of the status flags selected by the mask. The channel can halt itself on an RC match, either by stopping the count or by turning the channel clock off. The external event can also act as a trigger that restarts the count.

Top module: `wave_timer_chan`

## Requirements
- R1: After synchronous reset the counter reads 0. Outputs A and B are low, `irq` is low, the status word reads 0, the mask reads 0, the channel clock is off and the counter is stopped.
- R2: Register word addresses are: 0 command, 1 mode, 2 counter (read-only), 3 RA, 4 RB, 5 RC, 6 status, 7 mask-set, 8 mask-clear, 9 mask. Command bit 0 turns the channel clock on and bit 1 turns it off. When both are written together, off wins. Status bit 16 shows the clock state.
- R3: The counter moves only in a cycle where the clock is on, the counter has been started by a trigger and `cnt_tick` is high. In count style 0 (mode bits [1:0]) it counts up and wraps from full scale to 0. The step that leaves full scale sets status bit 0.
- R4: In count style 2 the counter steps from the RC value back to 0, so it cycles through RC+1 values.
- R5: In count style 1 the counter counts up to full scale and then down to 0, over and over. In count style 3 it turns around at RC instead of full scale. The step out of full scale in style 1 sets status bit 0.
- R6: A counter step that lands on RA, RB or RC sets status bit 2, 3 or 4 respectively. A trigger never produces a match.
- R7: Action codes are 0 none, 1 set, 2 clear, 3 toggle. Output A fields in the mode register are RA match [9:8], RC match [11:10], external event [13:12] and software trigger [15:14]. Output B fields are RB match [17:16], RC match [19:18], external event [21:20] and software trigger [23:22].
- R8: When several events with a non-zero action reach one output in the same cycle, only one is applied. The order from highest to lowest is software trigger, external event, RC match, then the RA or RB match.
- R9: Command bit 2 is the software trigger. It clears the counter, sets the direction to up, starts the counter and applies the software-trigger actions.
- R10: Mode bits [3:2] select which edges of `ext_evt` count as an event: 0 none, 1 rising, 2 falling, 3 both. A detected edge sets status bit 7 and applies the external-event actions. When mode bit 4 is set, the edge also clears and restarts the counter.
- R11: Mode bit 5 makes an RC match stop the counter while the clock stays on. Mode bit 6 makes an RC match turn the clock off, and a later clock-on command resumes counting from where it stopped.
- R12: Reading the status word returns bits 0 to 7 and then clears them. An event in the same cycle as the read still sets its bit. Bits 16, 17 and 18 always show the clock state and the levels of outputs A and B.
- R13: Writing 1s to the mask-set address sets mask bits, and writing 1s to the mask-clear address clears them. The mask reads back at address 9. `irq` is high while any status bit in 0 to 7 has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; reading the status word clears its flags |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| cnt_tick | input | 1 | Count enable strobe |
| ext_evt | input | 1 | External event level |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt, OR of the masked status flags |

## Verification
The assertions take three things for granted. First, `cnt_tick`, `ext_evt` and the register strobes are synchronous to `clk`. Second, `ext_evt` is low when reset is released. Third, at most one register access happens in a cycle. The bound on the counter in count style 2 also assumes that neither RC nor the mode is rewritten while that property is being evaluated. The bench changes every input on the falling clock edge and holds `ext_evt` low through reset. It issues one access per cycle and writes RC and the mode only while the counter is idle or just before a trigger. It keeps RC non-zero whenever count style 3 is selected.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int BUS_DW  = 32;
    localparam int ADDR_W  = 4;
    localparam int MODE_W  = 24;
    localparam int FLAG_W  = 8;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CMD  = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_RA   = 4'd3;
    localparam logic [ADDR_W-1:0] A_RB   = 4'd4;
    localparam logic [ADDR_W-1:0] A_RC   = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd6;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd7;
    localparam logic [ADDR_W-1:0] A_IDIS = 4'd8;
    localparam logic [ADDR_W-1:0] A_MASK = 4'd9;

    // command bits
    localparam int CMD_ON   = 0;
    localparam int CMD_OFF  = 1;
    localparam int CMD_TRIG = 2;

    // status flag positions
    localparam int ST_OVF = 0;
    localparam int ST_MA  = 2;
    localparam int ST_MB  = 3;
    localparam int ST_MC  = 4;
    localparam int ST_EVT = 7;

    typedef enum logic [1:0] {
        WV_UP_FULL  = 2'd0,
        WV_UPDN_FULL = 2'd1,
        WV_UP_RC    = 2'd2,
        WV_UPDN_RC  = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        EDG_NONE = 2'd0,
        EDG_RISE = 2'd1,
        EDG_FALL = 2'd2,
        EDG_BOTH = 2'd3
    } edge_e;

    // per-output action set, highest priority in the top bits
    typedef struct packed {
        act_e sw;
        act_e evt;
        act_e rc;
        act_e cmp;
    } pin_act_t;

    typedef struct packed {
        logic sw;
        logic evt;
        logic rc;
        logic cmp;
    } pin_ev_t;

    typedef struct packed {
        pin_act_t b;
        pin_act_t a;
        logic     spare;
        logic     dis_rc;
        logic     stop_rc;
        logic     evt_trig;
        edge_e    evt_edge;
        wave_e    wave;
    } mode_t;

    // resolve the winning action and apply it to the current level
    function automatic logic next_pin(input logic cur, input pin_act_t act,
                                      input pin_ev_t ev);
        act_e sel;
        logic res;
        sel = ACT_NONE;
        if (ev.cmp && act.cmp != ACT_NONE) sel = act.cmp;
        if (ev.rc  && act.rc  != ACT_NONE) sel = act.rc;
        if (ev.evt && act.evt != ACT_NONE) sel = act.evt;
        if (ev.sw  && act.sw  != ACT_NONE) sel = act.sw;
        case (sel)
            ACT_SET: res = 1'b1;
            ACT_CLR: res = 1'b0;
            ACT_TGL: res = ~cur;
            default: res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/wtc_edge.sv
module wtc_edge
    import wtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    input  edge_e sel,
    output logic  hit
);
    logic din_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) din_q <= 1'b0;
        else     din_q <= din;
    end

    assign rise = din & ~din_q;
    assign fall = ~din & din_q;

    always_comb begin
        case (sel)
            EDG_RISE: hit = rise;
            EDG_FALL: hit = fall;
            EDG_BOTH: hit = rise | fall;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             trig,
    input  wave_e            wave,
    input  logic [CNT_W-1:0] ra,
    input  logic [CNT_W-1:0] rb,
    input  logic [CNT_W-1:0] rc,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_ra,
    output logic             hit_rb,
    output logic             hit_rc,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL = '1;
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic             up_q;
    logic             up_n;
    logic [CNT_W-1:0] nxt;
    logic             wrap;
    logic             at_top;
    logic             adv;

    always_comb begin
        nxt    = cnt + 1'b1;
        up_n   = up_q;
        wrap   = 1'b0;
        at_top = (cnt == FULL) || ((wave == WV_UPDN_RC) && (cnt == rc));
        case (wave)
            WV_UP_FULL: wrap = (cnt == FULL);
            WV_UP_RC: begin
                if (cnt == rc) nxt = ZERO;
                else           wrap = (cnt == FULL);
            end
            default: begin
                if (up_q) begin
                    if (at_top) begin
                        nxt  = cnt - 1'b1;
                        up_n = 1'b0;
                        wrap = (cnt == FULL);
                    end
                end else if (cnt == ZERO) begin
                    up_n = 1'b1;
                end else begin
                    nxt = cnt - 1'b1;
                end
            end
        endcase
    end

    assign adv    = step && !trig;
    assign hit_ra = adv && (nxt == ra);
    assign hit_rb = adv && (nxt == rb);
    assign hit_rc = adv && (nxt == rc);
    assign ovf    = adv && wrap;

    always_ff @(posedge clk) begin
        if (rst || trig) begin
            cnt  <= ZERO;
            up_q <= 1'b1;
        end else if (adv) begin
            cnt  <= nxt;
            up_q <= up_n;
        end
    end
endmodule

// File: rtl/wtc_pin_unit.sv
module wtc_pin_unit
    import wtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_act_t act,
    input  pin_ev_t  ev,
    output logic     pin
);
    always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else     pin <= next_pin(pin, act, ev);
    end
endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              cnt_tick,
    input  logic              ext_evt,
    output logic              out_a,
    output logic              out_b,
    output logic              irq
);
    localparam int NPIN = 2;

    logic [CNT_W-1:0] ra_q, rb_q, rc_q, cnt_q;
    mode_t            mode_q;
    logic             clk_on, run_q;
    logic [FLAG_W-1:0] sts_q, mask_q, sts_set;

    logic wr_cmd, sw_trig, evt_hit, trig, step;
    logic hit_ra, hit_rb, hit_rc, ovf;

    assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
    assign sw_trig = wr_cmd && bus_wdata[CMD_TRIG];
    assign trig    = sw_trig || (evt_hit && mode_q.evt_trig);
    assign step    = clk_on && run_q && cnt_tick;

    wtc_edge u_edge (
        .clk (clk),
        .rst (rst),
        .din (ext_evt),
        .sel (mode_q.evt_edge),
        .hit (evt_hit)
    );

    wtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .trig   (trig),
        .wave   (mode_q.wave),
        .ra     (ra_q),
        .rb     (rb_q),
        .rc     (rc_q),
        .cnt    (cnt_q),
        .hit_ra (hit_ra),
        .hit_rb (hit_rb),
        .hit_rc (hit_rc),
        .ovf    (ovf)
    );

    pin_act_t pin_act [NPIN];
    pin_ev_t  pin_ev  [NPIN];
    logic     pin_lvl [NPIN];

    assign pin_act[0] = mode_q.a;
    assign pin_act[1] = mode_q.b;
    assign pin_ev[0]  = '{sw: sw_trig, evt: evt_hit, rc: hit_rc, cmp: hit_ra};
    assign pin_ev[1]  = '{sw: sw_trig, evt: evt_hit, rc: hit_rc, cmp: hit_rb};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        wtc_pin_unit u_pin (
            .clk (clk),
            .rst (rst),
            .act (pin_act[g]),
            .ev  (pin_ev[g]),
            .pin (pin_lvl[g])
        );
    end

    assign out_a = pin_lvl[0];
    assign out_b = pin_lvl[1];

    // channel clock and run state
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_on <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (wr_cmd && bus_wdata[CMD_OFF])   clk_on <= 1'b0;
            else if (hit_rc && mode_q.dis_rc)   clk_on <= 1'b0;
            else if (wr_cmd && bus_wdata[CMD_ON]) clk_on <= 1'b1;

            if (trig)                          run_q <= 1'b1;
            else if (hit_rc && mode_q.stop_rc) run_q <= 1'b0;
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            rc_q   <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_MODE: mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
                A_RA:   ra_q   <= bus_wdata[CNT_W-1:0];
                A_RB:   rb_q   <= bus_wdata[CNT_W-1:0];
                A_RC:   rc_q   <= bus_wdata[CNT_W-1:0];
                A_IEN:  mask_q <= mask_q | bus_wdata[FLAG_W-1:0];
                A_IDIS: mask_q <= mask_q & ~bus_wdata[FLAG_W-1:0];
                default: ;
            endcase
        end
    end

    // sticky flags, cleared by a status read, new events win
    always_comb begin
        sts_set         = '0;
        sts_set[ST_OVF] = ovf;
        sts_set[ST_MA]  = hit_ra;
        sts_set[ST_MB]  = hit_rb;
        sts_set[ST_MC]  = hit_rc;
        sts_set[ST_EVT] = evt_hit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sts_q <= '0;
        else if (bus_rd && (bus_addr == A_STAT))
            sts_q <= sts_set;
        else
            sts_q <= sts_q | sts_set;
    end

    assign irq = |(sts_q & mask_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: bus_rdata[MODE_W-1:0] = mode_q;
            A_CNT:  bus_rdata[CNT_W-1:0]  = cnt_q;
            A_RA:   bus_rdata[CNT_W-1:0]  = ra_q;
            A_RB:   bus_rdata[CNT_W-1:0]  = rb_q;
            A_RC:   bus_rdata[CNT_W-1:0]  = rc_q;
            A_STAT: bus_rdata = {13'd0, out_b, out_a, clk_on, 8'd0, sts_q};
            A_MASK: bus_rdata[FLAG_W-1:0] = mask_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              cnt_tick,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  rc,
    input wave_e             wave,
    input logic              clk_on,
    input logic              trig
);
    assert_off_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CMD && bus_wdata[CMD_OFF]) |=> !clk_on);

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_tick && !trig) |=> $stable(cnt));

    assert_rc_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (wave == WV_UP_RC && cnt <= rc && !bus_wr) |=> (cnt <= rc));

    assert_trig_clears_R9: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cnt == '0));

    assert_mask_off_R13: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_IDIS && bus_wdata[FLAG_W-1:0] == '1) |=> !irq);
endmodule

bind wave_timer_chan wtc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_tick  (cnt_tick),
    .irq       (irq),
    .cnt       (cnt_q),
    .rc        (rc_q),
    .wave      (mode_q.wave),
    .clk_on    (clk_on),
    .trig      (trig)
);

// File: tb/tb_wave_timer_chan.sv
module tb_wave_timer_chan;
    localparam int PERIOD = 10;
    localparam int W = 4;
    localparam logic [3:0] CMD = 0, MODE = 1, CNT = 2, RA = 3, RB = 4, RC = 5,
                           STAT = 6, IEN = 7, IDIS = 8, MASK = 9;

    logic        clk = 0, rst = 1;
    logic        bus_wr = 0, bus_rd = 0, cnt_tick = 0, ext_evt = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        out_a, out_b, irq;
    int          n_run = 0, n_fail = 0;
    logic [31:0] v;
    logic        prev;

    wave_timer_chan #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .ext_evt(ext_evt),
        .out_a(out_a), .out_b(out_b), .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cnt_tick = 1;
        repeat (n) @(negedge clk);
        cnt_tick = 0;
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(CNT, v);  chk("R1 counter", v, 0);
        rd(STAT, v); chk("R1 status", v, 0);
        rd(MASK, v); chk("R1 mask", v, 0);
        chk("R1 pins/irq", {out_a, out_b, irq}, 0);

        // R2 clock on/off, off wins
        wr(CMD, 1); rd(STAT, v); chk("R2 clock on", v, 32'h10000);
        wr(CMD, 3); rd(STAT, v); chk("R2 off wins", v, 0);
        wr(CMD, 1);

        // R3/R6 up to full scale
        wr(RA, 5); wr(RB, 7); wr(RC, 12); wr(MODE, 0);
        wr(CMD, 4); ticks(10);
        rd(CNT, v);  chk("R3 count 10", v, 10);
        rd(STAT, v); chk("R6 RA/RB flags", v, 32'h1000C);
        rd(STAT, v); chk("R12 read clears", v, 32'h10000);
        wr(CMD, 2); ticks(3);
        rd(CNT, v);  chk("R3 hold when off", v, 10);
        wr(CMD, 1); ticks(6);
        rd(CNT, v);  chk("R3 wrap", v, 0);
        rd(STAT, v); chk("R3 overflow R6 RC flag", v, 32'h10011);

        // R4 up with reset at RC, swept over RC
        wr(MODE, 2);
        for (int rc = 1; rc <= 14; rc++) begin
            wr(RC, rc); wr(CMD, 4); ticks(rc + 3);
            rd(CNT, v); chk("R4 cycle", v, (rc + 3) % (rc + 1));
        end
        rd(STAT, v);

        // R5 up/down turning at RC
        wr(MODE, 3); wr(RC, 6);
        for (int n = 1; n <= 14; n++) begin
            wr(CMD, 4); ticks(n);
            rd(CNT, v); chk("R5 style3", v, (n % 12) <= 6 ? n % 12 : 12 - (n % 12));
        end
        // R5 up/down at full scale
        wr(MODE, 1); rd(STAT, v);
        for (int n = 12; n <= 32; n += 4) begin
            wr(CMD, 4); ticks(n);
            rd(CNT, v); chk("R5 style1", v, (n % 30) <= 15 ? n % 30 : 30 - (n % 30));
        end
        rd(STAT, v); chk("R5 overflow flag", v[0], 1);

        // R7 action fields
        wr(RA, 3); wr(RB, 5); wr(RC, 8);
        wr(MODE, (1 << 8) | (2 << 10) | (3 << 16));
        wr(CMD, 4); ticks(3);
        chk("R7 A set on RA", {out_a, out_b}, 2'b10);
        ticks(2);
        chk("R7 B toggle on RB", {out_a, out_b}, 2'b11);
        ticks(3);
        chk("R7 A clear on RC", {out_a, out_b}, 2'b01);
        rd(STAT, v); chk("R12 mirrors", v, 32'h5001C);

        // R8/R9 priority of RC over RA, software action
        wr(RA, 4); wr(RC, 4);
        wr(MODE, (1 << 14) | (3 << 10) | (1 << 8));
        wr(CMD, 4);
        chk("R9 sw set", out_a, 1);
        rd(CNT, v); chk("R9 counter cleared", v, 0);
        ticks(4);
        chk("R8 RC beats RA", out_a, 0);

        // R8 software beats external event
        wr(MODE, (1 << 14) | (2 << 12) | (1 << 2));
        @(negedge clk);
        ext_evt = 1; bus_wr = 1; bus_addr = CMD; bus_wdata = 4;
        @(negedge clk);
        bus_wr = 0;
        chk("R8 sw beats event", out_a, 1);
        ext_evt = 0; @(negedge clk);
        chk("R10 falling ignored", out_a, 1);
        ext_evt = 1; @(negedge clk);
        chk("R10 rising clears", out_a, 0);
        ext_evt = 0; @(negedge clk);

        // R10 edge select sweep with trigger on event
        rd(STAT, v);
        for (int e = 0; e < 4; e++) begin
            wr(MODE, (3 << 20) | (1 << 4) | (e << 2));
            wr(CMD, 4); ticks(5);
            prev = out_b;
            @(negedge clk); ext_evt = 1; @(negedge clk);
            chk("R10 rise", out_b, prev ^ e[0]);
            prev = out_b;
            ext_evt = 0; @(negedge clk);
            chk("R10 fall", out_b, prev ^ e[1]);
            rd(CNT, v);  chk("R10 restart", v, e == 0 ? 5 : 0);
            rd(STAT, v); chk("R10 event flag", v[7], e != 0);
        end

        // R11 stop and disable on RC
        wr(RC, 4); wr(MODE, 2 | (1 << 5));
        wr(CMD, 4); ticks(10);
        rd(CNT, v);  chk("R11 stop", v, 4);
        rd(STAT, v); chk("R11 clock stays on", v[16], 1);
        wr(MODE, 2 | (1 << 6));
        wr(CMD, 4); ticks(10);
        rd(CNT, v);  chk("R11 disable", v, 4);
        rd(STAT, v); chk("R11 clock off", v[16], 0);
        wr(CMD, 1); ticks(1);
        rd(CNT, v);  chk("R11 resume", v, 0);

        // R13 interrupt mask
        wr(MODE, 2); rd(STAT, v);
        wr(IEN, 32'h10); rd(MASK, v); chk("R13 mask set", v, 32'h10);
        wr(CMD, 4); ticks(4);
        chk("R13 irq on RC", irq, 1);
        rd(STAT, v); chk("R13 irq after read", irq, 0);
        wr(IDIS, 32'h10); rd(MASK, v); chk("R13 mask clear", v, 0);
        ticks(5);
        chk("R13 masked irq", irq, 0);
        rd(STAT, v); chk("R12 flag kept while masked", v[4], 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule